// File: doc/BRIEF.md
# Serial NOR Flash Program and Erase Sequencer

This block writes and erases a serial NOR flash through a single-lane SPI bus in mode 0. A host pulses `start_i` with an operation, a byte offset and a byte length. The block checks the request and then drives the whole flash command sequence with no further help from the host. Program data comes in one byte at a time over a ready/valid stream, in order. Each request ends with exactly one `done_o` pulse, and `err_o` is set with that pulse when the request was refused.

The sequence for an accepted, non-empty request has four parts. First, one chip-select window carries two 0xFF bytes, which takes the flash out of any continuous-read mode. Second, status is polled until the flash is idle. Third, the work is split into chunks: a program chunk ends at the next page boundary or at the end of the request, and an erase chunk is one erase block. Fourth, each chunk runs as a write-enable, a status poll that confirms the write-enable latch is set, the command with its address (and data for a program), and a status poll until the write-in-progress bit clears.

Controller states: `ST_IDLE` (waits for start), `ST_CHECK` (validates the request), `ST_EXIT` (sends the 0xFF 0xFF window), `ST_STAT_CMD` and `ST_STAT_RD` (the status poll window), `ST_WREN` (the write-enable window), `ST_OPCODE` (opcode plus three address bytes), `ST_DATA` (program payload), `ST_GAP` (chip select held high between windows) and `ST_FINISH` (done pulse).

Transitions:
- `ST_IDLE` to `ST_CHECK` on start.
- `ST_CHECK` to `ST_FINISH` when the request is bad or has zero length, otherwise to `ST_EXIT`.
- `ST_EXIT`, `ST_WREN`, `ST_STAT_RD`, the end of an erase `ST_OPCODE` and the end of `ST_DATA` all go to `ST_GAP`. `ST_GAP` then moves on to the state chosen when the window closed.
- `ST_STAT_CMD` to `ST_STAT_RD` after the 0x05 byte.
- A status byte with the busy bit set polls again. Once the busy bit is clear, the next step depends on why the poll was made: after the exit window it goes to write-enable; after a write-enable it goes to the command if the latch is set, and to write-enable again if not; after a chunk it goes to write-enable if work remains, otherwise to `ST_FINISH`.
- A program `ST_OPCODE` goes to `ST_DATA`.

Top module: `nor_prog_seq`

## Requirements
- R1: A request whose offset plus length is greater than `CAP_BYTES` ends with `done_o` and `err_o` high, and chip select is never driven low.
- R2: An erase (`op_i`=1) whose offset or length is not a multiple of 2^`EB_LOG2` ends with `done_o` and `err_o` high, and there is no bus activity.
- R3: A valid request of length zero ends with `done_o` high, `err_o` low and no chip-select activity.
- R4: The first window of an accepted request carries exactly two 0xFF bytes. Status is then polled until the flash is idle, before any other command is sent.
- R5: Status is read by sending 0x05 and clocking in one byte in the same window. Bit 0 of that byte means busy and bit 1 means the write-enable latch is set.
- R6: Write-enable is the byte 0x06 alone in its own window, followed by status polling. If bit 1 is still clear when the flash is idle, write-enable is sent again.
- R7: A program chunk is one window holding 0x02, a 24-bit address (most significant byte first) and the data. Its length is the smaller of the remaining length and 256 minus (address mod 256).
- R8: After every chunk, status is polled until idle. Each following chunk is preceded by a new write-enable, and no command other than a status read reaches a busy flash.
- R9: An erase sends 0x20 with a 24-bit big-endian address, once for each erase block, with the address advancing by 2^`EB_LOG2`.
- R10: `busy_o` is high from the cycle after a start is accepted until `done_o`. `done_o` pulses exactly once per request.
- R11: SCK rests low, MOSI changes only while SCK is low, and MISO is sampled on the rising edge of SCK.
- R12: `wr_ready_o` is high only during the data phase of a program, and exactly the requested number of bytes is taken, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken while idle |
| op_i | input | 1 | 0 = program, 1 = erase |
| offset_i | input | ADDR_W | Start byte offset |
| len_i | input | ADDR_W+1 | Length in bytes |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Request refused; valid with done_o |
| wr_data_i | input | 8 | Program data byte |
| wr_valid_i | input | 1 | Program data valid |
| wr_ready_o | output | 1 | Program data accepted |
| spi_sck_o | output | 1 | SPI clock, mode 0 |
| spi_cs_n_o | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with a 16 KiB capacity, 4 KiB erase blocks, 256-byte pages and a half-period of two system clocks. With these values the capacity limit, a two-block erase and page splitting can all be reached in a few thousand cycles. A program at offset 250 crosses a page boundary after six bytes, and a full 256-byte page exercises the single-chunk case. The flash model starts busy, so the polling that follows the exit window is exercised, and it can ignore one write-enable, so the retry path is exercised.

// File: rtl/nps_pkg.sv
package nps_pkg;

    localparam logic [7:0] CMD_EXIT   = 8'hFF;
    localparam logic [7:0] CMD_STATUS = 8'h05;
    localparam logic [7:0] CMD_WREN   = 8'h06;
    localparam logic [7:0] CMD_PROG   = 8'h02;
    localparam logic [7:0] CMD_ERASE  = 8'h20;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_EXIT,
        ST_STAT_CMD,
        ST_STAT_RD,
        ST_WREN,
        ST_OPCODE,
        ST_DATA,
        ST_GAP,
        ST_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {
        PL_EXIT,
        PL_WREN,
        PL_CHUNK
    } poll_why_e;

endpackage

// File: rtl/nps_req_check.sv
module nps_req_check #(
    parameter int          ADDR_W    = 24,
    parameter int          LEN_W     = ADDR_W + 1,
    parameter longint      CAP_BYTES = 16777216,
    parameter int          EB_LOG2   = 12
) (
    input  logic              op_erase,
    input  logic [ADDR_W-1:0] offset,
    input  logic [LEN_W-1:0]  len,
    output logic              bad
);
    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] end_pos;
    logic             over_cap;
    logic             misalign;

    always_comb begin
        end_pos  = SUM_W'(offset) + SUM_W'(len);
        over_cap = end_pos > SUM_W'(CAP_BYTES);
        misalign = op_erase && ((|offset[EB_LOG2-1:0]) || (|len[EB_LOG2-1:0]));
        bad      = over_cap || misalign;
    end

endmodule

// File: rtl/nps_spi_byte.sv
module nps_spi_byte #(
    parameter int HALF_DIV  = 2,
    parameter int STAT_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic [7:0]           tx_byte,
    output logic                 done,
    output logic [STAT_BITS-1:0] rx_low,
    output logic                 sck,
    output logic                 mosi,
    input  logic                 miso
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic                 active_q;
    logic                 sck_q;
    logic [DIV_W-1:0]     div_q;
    logic [2:0]           bit_q;
    logic [7:0]           sh_tx_q;
    logic [STAT_BITS-1:0] sh_rx_q;
    logic                 done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sck_q    <= 1'b0;
            div_q    <= '0;
            bit_q    <= '0;
            sh_tx_q  <= '0;
            sh_rx_q  <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (go) begin
                    active_q <= 1'b1;
                    sh_tx_q  <= tx_byte;
                    div_q    <= '0;
                    bit_q    <= '0;
                    sck_q    <= 1'b0;
                end
            end else if (div_q == DIV_W'(HALF_DIV - 1)) begin
                div_q <= '0;
                if (!sck_q) begin
                    sck_q   <= 1'b1;
                    sh_rx_q <= {sh_rx_q[STAT_BITS-2:0], miso};
                end else begin
                    sck_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        bit_q   <= bit_q + 3'd1;
                        sh_tx_q <= {sh_tx_q[6:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + DIV_W'(1);
            end
        end
    end

    assign done   = done_q;
    assign rx_low = sh_rx_q;
    assign sck    = sck_q;
    assign mosi   = sh_tx_q[7];

    AST_SCK_REST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> !sck_q);  // R11
    AST_MOSI_HELD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_q) |-> $stable(sh_tx_q[7]));  // R11

endmodule

// File: rtl/nps_ctrl.sv
module nps_ctrl
    import nps_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int LEN_W     = ADDR_W + 1,
    parameter int PAGE_LOG2 = 8,
    parameter int EB_LOG2   = 12,
    parameter int GAP_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_i,
    input  logic [ADDR_W-1:0] offset_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              req_bad_i,
    output logic              op_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [LEN_W-1:0]  remain_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    input  logic [7:0]        wr_data_i,
    input  logic              wr_valid_i,
    output logic              wr_ready_o,
    output logic              cs_n_o,
    output logic              tx_go_o,
    output logic [7:0]        tx_byte_o,
    input  logic              tx_done_i,
    input  logic [1:0]        stat_i
);
    localparam int           GAP_W   = $clog2(GAP_CYC + 1);
    localparam logic [LEN_W-1:0] PAGE_LEN = LEN_W'(1) << PAGE_LOG2;
    localparam logic [LEN_W-1:0] EB_LEN   = LEN_W'(1) << EB_LOG2;

    seq_state_e        state_q, state_d;
    seq_state_e        after_q, after_d;
    poll_why_e         why_q, why_d;
    logic              op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic [LEN_W-1:0]  chunk_q;
    logic [1:0]        idx_q;
    logic              pend_q;
    logic [GAP_W-1:0]  gap_q;
    logic              cs_n_q;
    logic              err_q;

    logic [LEN_W-1:0]  page_room;
    logic [LEN_W-1:0]  chunk_sel;
    logic [23:0]       addr24;
    logic              win_active;

    always_comb begin
        page_room = PAGE_LEN - LEN_W'(addr_q[PAGE_LOG2-1:0]);
        if (op_q)
            chunk_sel = EB_LEN;
        else
            chunk_sel = (remain_q < page_room) ? remain_q : page_room;
        addr24 = 24'(addr_q);
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        after_d    = after_q;
        why_d      = why_q;
        tx_go_o    = 1'b0;
        tx_byte_o  = 8'h00;
        wr_ready_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (req_bad_i || remain_q == '0) state_d = ST_FINISH;
                else                             state_d = ST_EXIT;
            end
            ST_EXIT: begin
                tx_byte_o = CMD_EXIT;
                tx_go_o   = !pend_q;
                if (tx_done_i && idx_q == 2'd1) begin
                    state_d = ST_GAP;
                    after_d = ST_STAT_CMD;
                    why_d   = PL_EXIT;
                end
            end
            ST_STAT_CMD: begin
                tx_byte_o = CMD_STATUS;
                tx_go_o   = !pend_q;
                if (tx_done_i) state_d = ST_STAT_RD;
            end
            ST_STAT_RD: begin
                tx_byte_o = 8'h00;
                tx_go_o   = !pend_q;
                if (tx_done_i) begin
                    state_d = ST_GAP;
                    if (stat_i[0]) begin
                        after_d = ST_STAT_CMD;
                    end else begin
                        unique case (why_q)
                            PL_EXIT:  after_d = ST_WREN;
                            PL_WREN:  after_d = stat_i[1] ? ST_OPCODE : ST_WREN;
                            PL_CHUNK: after_d = (remain_q == '0) ? ST_FINISH : ST_WREN;
                            default:  after_d = ST_FINISH;
                        endcase
                    end
                end
            end
            ST_WREN: begin
                tx_byte_o = CMD_WREN;
                tx_go_o   = !pend_q;
                if (tx_done_i) begin
                    state_d = ST_GAP;
                    after_d = ST_STAT_CMD;
                    why_d   = PL_WREN;
                end
            end
            ST_OPCODE: begin
                unique case (idx_q)
                    2'd0: tx_byte_o = op_q ? CMD_ERASE : CMD_PROG;
                    2'd1: tx_byte_o = addr24[23:16];
                    2'd2: tx_byte_o = addr24[15:8];
                    default: tx_byte_o = addr24[7:0];
                endcase
                tx_go_o = !pend_q;
                if (tx_done_i && idx_q == 2'd3) begin
                    if (op_q) begin
                        state_d = ST_GAP;
                        after_d = ST_STAT_CMD;
                        why_d   = PL_CHUNK;
                    end else begin
                        state_d = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                wr_ready_o = !pend_q;
                tx_go_o    = wr_valid_i && !pend_q;
                tx_byte_o  = wr_data_i;
                if (tx_done_i && chunk_q == LEN_W'(1)) begin
                    state_d = ST_GAP;
                    after_d = ST_STAT_CMD;
                    why_d   = PL_CHUNK;
                end
            end
            ST_GAP: begin
                if (gap_q == GAP_W'(GAP_CYC - 1)) state_d = after_q;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        win_active = (state_d == ST_EXIT) || (state_d == ST_STAT_CMD) ||
                     (state_d == ST_STAT_RD) || (state_d == ST_WREN) ||
                     (state_d == ST_OPCODE) || (state_d == ST_DATA);
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            after_q  <= ST_IDLE;
            why_q    <= PL_EXIT;
            op_q     <= 1'b0;
            addr_q   <= '0;
            remain_q <= '0;
            chunk_q  <= '0;
            idx_q    <= '0;
            pend_q   <= 1'b0;
            gap_q    <= '0;
            cs_n_q   <= 1'b1;
            err_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            after_q <= after_d;
            why_q   <= why_d;
            cs_n_q  <= !win_active;

            if (state_q == ST_IDLE && start_i) begin
                op_q     <= op_i;
                addr_q   <= offset_i;
                remain_q <= len_i;
            end

            if (state_q == ST_CHECK) err_q <= req_bad_i;

            if (tx_go_o)        pend_q <= 1'b1;
            else if (tx_done_i) pend_q <= 1'b0;

            if (state_d != state_q) idx_q <= '0;
            else if (tx_done_i)     idx_q <= idx_q + 2'd1;

            gap_q <= (state_q == ST_GAP) ? gap_q + GAP_W'(1) : '0;

            if (state_q == ST_OPCODE && tx_done_i && idx_q == 2'd3) begin
                chunk_q  <= chunk_sel;
                addr_q   <= addr_q + ADDR_W'(chunk_sel);
                remain_q <= remain_q - chunk_sel;
            end else if (state_q == ST_DATA && tx_done_i) begin
                chunk_q <= chunk_q - LEN_W'(1);
            end
        end
    end

    assign op_o     = op_q;
    assign addr_o   = addr_q;
    assign remain_o = remain_q;
    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = (state_q == ST_FINISH);
    assign err_o    = (state_q == ST_FINISH) && err_q;
    assign cs_n_o   = cs_n_q;

    AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R10
    AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> cs_n_q);  // R3
    AST_DATA_ONLY_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready_o |-> (!op_q && !cs_n_q));  // R12
    AST_CHUNK_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (chunk_q != '0 && chunk_q <= PAGE_LEN));  // R7
    AST_REFUSED_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && req_bad_i) |=> cs_n_q);  // R1

endmodule

// File: rtl/nor_prog_seq.sv
module nor_prog_seq #(
    parameter int     ADDR_W    = 24,
    parameter longint CAP_BYTES = 16777216,
    parameter int     EB_LOG2   = 12,
    parameter int     PAGE_LOG2 = 8,
    parameter int     HALF_DIV  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_i,
    input  logic [ADDR_W-1:0] offset_i,
    input  logic [ADDR_W:0]   len_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    input  logic [7:0]        wr_data_i,
    input  logic              wr_valid_i,
    output logic              wr_ready_o,
    output logic              spi_sck_o,
    output logic              spi_cs_n_o,
    output logic              spi_mosi_o,
    input  logic              spi_miso_i
);
    localparam int LEN_W   = ADDR_W + 1;
    localparam int GAP_CYC = 2 * HALF_DIV;

    logic              op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic              req_bad;
    logic              tx_go;
    logic [7:0]        tx_byte;
    logic              tx_done;
    logic [1:0]        stat_low;

    nps_req_check #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .CAP_BYTES (CAP_BYTES),
        .EB_LOG2   (EB_LOG2)
    ) u_check (
        .op_erase (op_q),
        .offset   (addr_q),
        .len      (remain_q),
        .bad      (req_bad)
    );

    nps_ctrl #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .PAGE_LOG2 (PAGE_LOG2),
        .EB_LOG2   (EB_LOG2),
        .GAP_CYC   (GAP_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .op_i       (op_i),
        .offset_i   (offset_i),
        .len_i      (len_i),
        .req_bad_i  (req_bad),
        .op_o       (op_q),
        .addr_o     (addr_q),
        .remain_o   (remain_q),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .err_o      (err_o),
        .wr_data_i  (wr_data_i),
        .wr_valid_i (wr_valid_i),
        .wr_ready_o (wr_ready_o),
        .cs_n_o     (spi_cs_n_o),
        .tx_go_o    (tx_go),
        .tx_byte_o  (tx_byte),
        .tx_done_i  (tx_done),
        .stat_i     (stat_low)
    );

    nps_spi_byte #(
        .HALF_DIV  (HALF_DIV),
        .STAT_BITS (2)
    ) u_spi (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (tx_go),
        .tx_byte (tx_byte),
        .done    (tx_done),
        .rx_low  (stat_low),
        .sck     (spi_sck_o),
        .mosi    (spi_mosi_o),
        .miso    (spi_miso_i)
    );

endmodule

// File: tb/nor_prog_seq_tb.sv
module nor_prog_seq_tb;
    localparam int CLK_NS = 10;
    localparam int CAP    = 16384;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        op_i = 1'b0;
    logic [23:0] offset_i = '0;
    logic [24:0] len_i = '0;
    logic        busy_o, done_o, err_o;
    logic [7:0]  wr_data = 8'h30;
    logic        wr_valid = 1'b1;
    logic        wr_ready;
    logic        sck, cs_n, mosi;
    logic        miso = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    nor_prog_seq #(
        .ADDR_W(24), .CAP_BYTES(CAP), .EB_LOG2(12), .PAGE_LOG2(8), .HALF_DIV(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .offset_i(offset_i), .len_i(len_i), .busy_o(busy_o), .done_o(done_o),
        .err_o(err_o), .wr_data_i(wr_data), .wr_valid_i(wr_valid),
        .wr_ready_o(wr_ready), .spi_sck_o(sck), .spi_cs_n_o(cs_n),
        .spi_mosi_o(mosi), .spi_miso_i(miso)
    );

    typedef struct {
        logic [7:0] first;
        int         count;
        int         sum;
    } win_t;

    win_t  expq[$];
    int    checks = 0;
    int    fails = 0;
    string cur_req = "";

    // flash model state
    int         busy_left = 0;
    bit         wel = 0;
    bit         skip_wren = 0;
    int         proto_err = 0;
    int         stat_wins = 0;
    int         cs_falls = 0;
    int         mode_err = 0;
    int         done_cnt = 0;
    int         consumed = 0;
    logic [7:0] sr = '0;
    logic [7:0] out_sr = '0;
    int         bitc = 0;
    int         nbytes = 0;
    int         wsum = 0;
    logic [7:0] wfirst = '0;
    bit         load_st = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge cs_n) begin
        bitc = 0; nbytes = 0; wsum = 0; wfirst = '0; load_st = 0;
        cs_falls++;
    end

    always @(posedge sck) begin
        if (!cs_n) begin
            sr = {sr[6:0], mosi};
            bitc++;
            if (bitc == 8) begin
                bitc = 0;
                if (nbytes == 0) begin
                    wfirst = sr;
                    if (sr == 8'h05) load_st = 1;
                end
                wsum += int'(sr);
                nbytes++;
            end
        end
    end

    always @(negedge sck) begin
        if (!cs_n) begin
            if (load_st) begin
                out_sr  = {6'd0, wel, (busy_left != 0)};
                load_st = 0;
            end
            miso   = out_sr[7];
            out_sr = {out_sr[6:0], 1'b0};
        end
    end

    // flash behaviour and scoreboard monitor at the end of each window
    always @(posedge cs_n) begin
        if (nbytes > 0) begin
            case (wfirst)
                8'h05: begin
                    stat_wins++;
                    if (nbytes != 2) proto_err++;  // R5
                    if (busy_left > 0) busy_left--;
                end
                8'h06: begin
                    if (busy_left != 0 || nbytes != 1) proto_err++;  // R6 R8
                    if (skip_wren) skip_wren = 0;
                    else wel = 1;
                end
                8'h02, 8'h20: begin
                    if (busy_left != 0 || !wel) proto_err++;  // R8
                    wel = 0;
                    busy_left = 2;
                end
                default: ;
            endcase
            if (wfirst != 8'h05) begin
                if (expq.size() == 0) begin
                    check(0, {cur_req, " unexpected window"}, int'(wfirst), -1);
                end else begin
                    win_t e;
                    e = expq.pop_front();
                    check(e.first == wfirst && e.count == nbytes && e.sum == wsum,
                          {cur_req, " window first/count/sum"},
                          int'(wfirst) * 65536 + nbytes, int'(e.first) * 65536 + e.count);
                    if (e.sum != wsum)
                        $display("  window sum actual=%0d expected=%0d", wsum, e.sum);
                end
            end
        end
    end

    // data feeder and per-cycle observers, all away from the active edge
    initial begin
        bit   took = 0;
        logic sck_prev = 0;
        logic mosi_prev = 0;
        forever begin
            @(negedge clk);
            if (took) begin
                consumed++;
                wr_data = 8'(8'h30 + consumed);
            end
            took = wr_ready && wr_valid;
            if (done_o) done_cnt++;
            if (sck_prev && sck && (mosi != mosi_prev)) mode_err++;  // R11
            sck_prev  = sck;
            mosi_prev = mosi;
        end
    end

    task automatic push_exit();
        expq.push_back('{8'hFF, 2, 510});
    endtask

    task automatic push_wren();
        expq.push_back('{8'h06, 1, 6});
    endtask

    task automatic push_cmd(input logic [7:0] opc, input int addr, input int nd, input int d0);
        int s;
        s = int'(opc) + ((addr >> 16) & 255) + ((addr >> 8) & 255) + (addr & 255);
        for (int k = 0; k < nd; k++) s += (8'h30 + d0 + k) & 255;
        expq.push_back('{opc, 4 + nd, s});
    endtask

    task automatic do_req(input bit op, input int off, input int len,
                          input bit exp_err, input string req);
        int c0;
        int d0;
        c0 = cs_falls;
        d0 = done_cnt;
        cur_req = req;
        @(negedge clk);
        op_i = op; offset_i = 24'(off); len_i = 25'(len); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, {req, " R10 busy after start"}, int'(busy_o), 1);
        while (!done_o) @(negedge clk);
        check(err_o == exp_err, {req, " error flag"}, int'(err_o), int'(exp_err));
        repeat (4) @(negedge clk);
        check(done_cnt - d0 == 1, {req, " R10 one done pulse"}, done_cnt - d0, 1);
        check(busy_o == 1'b0, {req, " R10 idle after done"}, int'(busy_o), 0);
        check(expq.size() == 0, {req, " all windows seen"}, expq.size(), 0);
        if (exp_err || len == 0)
            check(cs_falls == c0, {req, " no bus activity"}, cs_falls - c0, 0);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1, "R11 reset cs high", int'(cs_n), 1);
        check(sck == 1'b0, "R11 reset sck low", int'(sck), 0);
        check(busy_o == 1'b0, "R10 reset not busy", int'(busy_o), 0);
        check(done_o == 1'b0, "R10 reset no done", int'(done_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_req(0, 100, 0, 0, "R3 zero length");
        do_req(0, 16380, 10, 1, "R1 past capacity");
        do_req(1, 12288, 8192, 1, "R1 erase past capacity");
        do_req(1, 100, 4096, 1, "R2 erase offset misaligned");
        do_req(1, 4096, 100, 1, "R2 erase length misaligned");

        // R4 R5 R7 R8: flash starts busy, program crosses a page after 6 bytes
        busy_left = 3;
        base = consumed;
        push_exit(); push_wren();
        push_cmd(8'h02, 250, 6, base);
        push_wren();
        push_cmd(8'h02, 256, 4, base + 6);
        do_req(0, 250, 10, 0, "R7 page split");
        check(consumed - base == 10, "R12 bytes taken", consumed - base, 10);
        check(proto_err == 0, "R8 no command while busy", proto_err, 0);
        check(stat_wins >= 5, "R5 status polled", stat_wins, 5);

        // R6: first write-enable ignored
        skip_wren = 1;
        base = consumed;
        push_exit(); push_wren(); push_wren();
        push_cmd(8'h02, 4096, 3, base);
        do_req(0, 4096, 3, 0, "R6 write-enable retry");
        check(proto_err == 0, "R6 latch confirmed", proto_err, 0);

        // R9: two erase blocks
        base = consumed;
        push_exit(); push_wren();
        push_cmd(8'h20, 4096, 0, 0);
        push_wren();
        push_cmd(8'h20, 8192, 0, 0);
        do_req(1, 4096, 8192, 0, "R9 two block erase");
        check(consumed == base, "R12 erase takes no data", consumed - base, 0);

        // R7: a whole aligned page in one chunk
        base = consumed;
        push_exit(); push_wren();
        push_cmd(8'h02, 512, 256, base);
        do_req(0, 512, 256, 0, "R7 full page");
        check(consumed - base == 256, "R12 full page bytes", consumed - base, 256);

        check(proto_err == 0, "R8 protocol at end", proto_err, 0);
        check(mode_err == 0, "R11 mosi steady while sck high", mode_err, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_NS * 200000);
        checks++;
        fails++;
        $display("FAIL R10 watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule